// File: doc/BRIEF.md
# Paired Activation Window Trimmer

This block squeezes a stream of unsigned 8-bit activation pairs into a 16-bit code per pair. For each activation it picks a data-dependent 4-bit window and a shift of 0 to 4, so that the window shifted left by the shift approximates the original value. When exactly one activation of a pair is zero, the nonzero partner takes the whole 8-bit payload of the pair and is kept exact. Rounding of the window can be switched on per pair.

The same pipeline rebuilds the approximate 8-bit values from the code and multiplies them by two 8-bit weights. It uses two 4x8 multipliers, each followed by a barrel shifter. In trimmed mode each multiplier serves its own activation. In full-precision mode both multipliers work on the one nonzero partner, one on the low nibble and one on the high nibble, and their results are added. Results appear two clock cycles after the input, together with a valid flag.

Top module: `bwt_pair_trimmer`

## Requirements
- R1: For a value of 16 or more, the shift is the index of the highest set bit minus 3, and with rounding off the window is the value shifted right by that shift (truncation). Code layout of `pack_o`: [15] full-precision flag, [14] partner select (1 = B is the full one), [13:11] shift B, [10:8] shift A, [7:0] payload. In trimmed mode the payload is {window B, window A}.
- R2: A value below 16 gets shift 0 and a window equal to the value, whatever the rounding setting.
- R3: With `round_en_i` high, the bit just below the window rounds the window half up.
- R4: If rounding overflows a window of 15 below shift 4, the shift goes up by one and the window becomes 8.
- R5: If rounding overflows a window of 15 at shift 4, the window stays 15 and the shift stays 4.
- R6: If exactly one activation is zero, the full flag is 1, the select bit names the nonzero partner, both shift fields are 0, and the payload is the nonzero value.
- R7: If both activations are zero or both are nonzero, the full flag and the select bit are 0.
- R8: `exp_a_o`/`exp_b_o` give window << shift in trimmed mode. In full mode they give the exact value for the full partner and 0 for the other.
- R9: `prod_a_o`/`prod_b_o` equal the rebuilt value of each partner times that partner's weight.
- R10: `valid_o` follows `valid_i` with a latency of two cycles, and every data output belongs to the pair that was presented two cycles before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input pair valid |
| act_a_i | input | 8 | Activation A |
| act_b_i | input | 8 | Activation B |
| round_en_i | input | 1 | Round window half up |
| wgt_a_i | input | 8 | Weight for activation A |
| wgt_b_i | input | 8 | Weight for activation B |
| valid_o | output | 1 | Output valid |
| pack_o | output | 16 | Packed pair code |
| exp_a_o | output | 8 | Rebuilt activation A |
| exp_b_o | output | 8 | Rebuilt activation B |
| prod_a_o | output | 16 | Product for A |
| prod_b_o | output | 16 | Product for B |

## Verification
The hardest case to reach is a rounding carry out of the window. Only values whose top five bits from the leading one are all ones produce it, so random stimulus seldom lands at shift 4 with a carry. Directed pairs such as 0x7C, 0x1F, 0xF8 and 0xFF target the shift step and the saturation. Pairs with one zero partner, placed in either position, drive the split-nibble multiply path. A reference model computes the window by searching for the smallest shift that fits, rather than by locating the leading one.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  parameter int unsigned ACT_W     = 8;
  parameter int unsigned WIN_W     = 4;
  localparam int unsigned SHIFT_MAX = ACT_W - WIN_W;
  localparam int unsigned SHIFT_W   = $clog2(SHIFT_MAX + 1);
  localparam int unsigned MUL_W     = WIN_W + ACT_W;
  localparam int unsigned PROD_W    = 2 * ACT_W;
  localparam int unsigned NUM_LANE  = 2;

  typedef struct packed {
    logic               full;
    logic               sel_b;
    logic [SHIFT_W-1:0] sh_b;
    logic [SHIFT_W-1:0] sh_a;
    logic [ACT_W-1:0]   data;
  } pair_code_t;

  localparam int unsigned CODE_W = $bits(pair_code_t);
endpackage

// File: rtl/bwt_win_sel.sv
module bwt_win_sel
  import bwt_pkg::*;
(
  input  logic [ACT_W-1:0]   act_i,
  input  logic               rnd_i,
  output logic [WIN_W-1:0]   win_o,
  output logic [SHIFT_W-1:0] sh_o
);
  logic [SHIFT_W-1:0] sh_raw;
  logic [ACT_W:0]     ext;
  logic [WIN_W-1:0]   win_raw;
  logic               rbit;

  always_comb begin
    sh_raw = '0;
    for (int i = WIN_W; i < ACT_W; i++) begin
      if (act_i[i]) sh_raw = SHIFT_W'(i - int'(WIN_W) + 1);
    end
    // guard bit below the window lands in ext[0]
    ext     = {act_i, 1'b0} >> sh_raw;
    win_raw = ext[WIN_W:1];
    rbit    = ext[0];
    win_o   = win_raw;
    sh_o    = sh_raw;
    if (rnd_i && rbit) begin
      if (&win_raw) begin
        if (sh_raw < SHIFT_W'(SHIFT_MAX)) begin
          sh_o  = sh_raw + SHIFT_W'(1);
          win_o = {1'b1, {(WIN_W-1){1'b0}}};
        end
      end else begin
        win_o = win_raw + WIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/bwt_pair_pack.sv
module bwt_pair_pack
  import bwt_pkg::*;
(
  input  logic [ACT_W-1:0] act_a_i,
  input  logic [ACT_W-1:0] act_b_i,
  input  logic             rnd_i,
  output pair_code_t       code_o
);
  logic [ACT_W-1:0]   act   [NUM_LANE];
  logic [WIN_W-1:0]   win   [NUM_LANE];
  logic [SHIFT_W-1:0] shift [NUM_LANE];
  logic               zero_a, zero_b;

  assign act[0] = act_a_i;
  assign act[1] = act_b_i;

  for (genvar k = 0; k < NUM_LANE; k++) begin : g_lane
    bwt_win_sel u_sel (
      .act_i (act[k]),
      .rnd_i (rnd_i),
      .win_o (win[k]),
      .sh_o  (shift[k])
    );
  end

  assign zero_a = (act_a_i == '0);
  assign zero_b = (act_b_i == '0);

  always_comb begin
    code_o = '0;
    if (zero_a ^ zero_b) begin
      code_o.full  = 1'b1;
      code_o.sel_b = zero_a;
      code_o.data  = zero_a ? act_b_i : act_a_i;
    end else begin
      code_o.sh_a = shift[0];
      code_o.sh_b = shift[1];
      code_o.data = {win[1], win[0]};
    end
  end
endmodule

// File: rtl/bwt_expand_mac.sv
module bwt_expand_mac
  import bwt_pkg::*;
(
  input  pair_code_t        code_i,
  input  logic [ACT_W-1:0]  wgt_a_i,
  input  logic [ACT_W-1:0]  wgt_b_i,
  output logic [ACT_W-1:0]  exp_a_o,
  output logic [ACT_W-1:0]  exp_b_o,
  output logic [PROD_W-1:0] prod_a_o,
  output logic [PROD_W-1:0] prod_b_o
);
  logic [WIN_W-1:0]   nib [NUM_LANE];
  logic [ACT_W-1:0]   wop [NUM_LANE];
  logic [SHIFT_W-1:0] sh  [NUM_LANE];
  logic [MUL_W-1:0]   mul [NUM_LANE];
  logic [PROD_W-1:0]  shf [NUM_LANE];
  logic [ACT_W-1:0]   rebuilt [NUM_LANE];
  logic [PROD_W-1:0]  sum;

  // nibble lanes sit at the same payload positions in both modes
  assign nib[0] = code_i.data[WIN_W-1:0];
  assign nib[1] = code_i.data[2*WIN_W-1:WIN_W];

  always_comb begin
    if (code_i.full) begin
      wop[0] = code_i.sel_b ? wgt_b_i : wgt_a_i;
      wop[1] = wop[0];
      sh[0]  = '0;
      sh[1]  = SHIFT_W'(WIN_W);
    end else begin
      wop[0] = wgt_a_i;
      wop[1] = wgt_b_i;
      sh[0]  = code_i.sh_a;
      sh[1]  = code_i.sh_b;
    end
  end

  for (genvar k = 0; k < NUM_LANE; k++) begin : g_mul
    assign mul[k]     = MUL_W'(nib[k]) * MUL_W'(wop[k]);
    assign shf[k]     = PROD_W'(mul[k]) << sh[k];
    assign rebuilt[k] = ACT_W'(nib[k]) << sh[k];
  end

  assign sum = shf[0] + shf[1];

  always_comb begin
    if (code_i.full) begin
      exp_a_o  = code_i.sel_b ? '0 : code_i.data;
      exp_b_o  = code_i.sel_b ? code_i.data : '0;
      prod_a_o = code_i.sel_b ? '0 : sum;
      prod_b_o = code_i.sel_b ? sum : '0;
    end else begin
      exp_a_o  = rebuilt[0];
      exp_b_o  = rebuilt[1];
      prod_a_o = shf[0];
      prod_b_o = shf[1];
    end
  end
endmodule

// File: rtl/bwt_pair_trimmer.sv
module bwt_pair_trimmer
  import bwt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ACT_W-1:0]  act_a_i,
  input  logic [ACT_W-1:0]  act_b_i,
  input  logic              round_en_i,
  input  logic [ACT_W-1:0]  wgt_a_i,
  input  logic [ACT_W-1:0]  wgt_b_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] pack_o,
  output logic [ACT_W-1:0]  exp_a_o,
  output logic [ACT_W-1:0]  exp_b_o,
  output logic [PROD_W-1:0] prod_a_o,
  output logic [PROD_W-1:0] prod_b_o
);
  pair_code_t        code_d, code_q;
  logic [ACT_W-1:0]  wa_q, wb_q;
  logic              vld_q;
  logic [ACT_W-1:0]  exp_a_d, exp_b_d;
  logic [PROD_W-1:0] prod_a_d, prod_b_d;

  bwt_pair_pack u_pack (
    .act_a_i (act_a_i),
    .act_b_i (act_b_i),
    .rnd_i   (round_en_i),
    .code_o  (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      wa_q   <= '0;
      wb_q   <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        code_q <= code_d;
        wa_q   <= wgt_a_i;
        wb_q   <= wgt_b_i;
      end
    end
  end

  bwt_expand_mac u_mac (
    .code_i   (code_q),
    .wgt_a_i  (wa_q),
    .wgt_b_i  (wb_q),
    .exp_a_o  (exp_a_d),
    .exp_b_o  (exp_b_d),
    .prod_a_o (prod_a_d),
    .prod_b_o (prod_b_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      pack_o   <= '0;
      exp_a_o  <= '0;
      exp_b_o  <= '0;
      prod_a_o <= '0;
      prod_b_o <= '0;
    end else begin
      valid_o <= vld_q;
      if (vld_q) begin
        pack_o   <= code_q;
        exp_a_o  <= exp_a_d;
        exp_b_o  <= exp_b_d;
        prod_a_o <= prod_a_d;
        prod_b_o <= prod_b_d;
      end
    end
  end
endmodule

// File: rtl/bwt_pair_trimmer_chk.sv
module bwt_pair_trimmer_chk
  import bwt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [ACT_W-1:0]  wgt_a_i,
  input logic [ACT_W-1:0]  wgt_b_i,
  input logic              valid_o,
  input logic [CODE_W-1:0] pack_o,
  input logic [ACT_W-1:0]  exp_a_o,
  input logic [ACT_W-1:0]  exp_b_o,
  input logic [PROD_W-1:0] prod_a_o,
  input logic [PROD_W-1:0] prod_b_o
);
  pair_code_t pc;
  logic [1:0] since_rst;
  assign pc = pair_code_t'(pack_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  assert_full_no_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pc.full) |-> (pc.sh_a == '0 && pc.sh_b == '0 && pc.data != '0));

  assert_shift_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pc.full) |-> (pc.sh_a <= SHIFT_W'(SHIFT_MAX) && pc.sh_b <= SHIFT_W'(SHIFT_MAX)));

  assert_partner_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pc.full) |-> ((pc.sel_b ? exp_a_o : exp_b_o) == '0));

  assert_small_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pc.full && pc.sh_a == '0) |-> (exp_a_o < ACT_W'(1 << WIN_W)));

  assert_prod_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && valid_o) |-> (prod_a_o == PROD_W'(exp_a_o) * PROD_W'($past(wgt_a_i, 2))));

  assert_prod_b_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && valid_o) |-> (prod_b_o == PROD_W'(exp_b_o) * PROD_W'($past(wgt_b_i, 2))));
endmodule

bind bwt_pair_trimmer bwt_pair_trimmer_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .wgt_a_i  (wgt_a_i),
  .wgt_b_i  (wgt_b_i),
  .valid_o  (valid_o),
  .pack_o   (pack_o),
  .exp_a_o  (exp_a_o),
  .exp_b_o  (exp_b_o),
  .prod_a_o (prod_a_o),
  .prod_b_o (prod_b_o)
);

// File: tb/bwt_pair_trimmer_tb_top.sv
module bwt_pair_trimmer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  act_a = '0, act_b = '0, wgt_a = '0, wgt_b = '0;
  logic        rnd = 1'b0;
  logic        valid_o;
  logic [15:0] pack_o;
  logic [7:0]  exp_a, exp_b;
  logic [15:0] prod_a, prod_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  typedef struct {
    logic [15:0] pack;
    logic [7:0]  ea, eb;
    logic [15:0] pa, pb;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bwt_pair_trimmer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .act_a_i(act_a), .act_b_i(act_b), .round_en_i(rnd),
    .wgt_a_i(wgt_a), .wgt_b_i(wgt_b),
    .valid_o(valid_o), .pack_o(pack_o),
    .exp_a_o(exp_a), .exp_b_o(exp_b),
    .prod_a_o(prod_a), .prod_b_o(prod_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // smallest shift whose 4-bit window can hold the value
  task automatic model(input logic [7:0] v, input logic r,
                       output logic [3:0] w, output logic [2:0] s);
    int sh = 0;
    int wi;
    while (sh < 4 && int'(v) >= (16 << sh)) sh++;
    wi = int'(v) >> sh;
    if (r && sh > 0 && v[sh-1]) begin
      if (wi == 15) begin
        if (sh < 4) begin sh++; wi = 8; end
      end else wi++;
    end
    w = 4'(wi);
    s = 3'(sh);
  endtask

  task automatic send(logic [7:0] a, logic [7:0] b, logic [7:0] wa,
                      logic [7:0] wb, logic r, string tag);
    exp_t e;
    logic [3:0] w_a, w_b;
    logic [2:0] s_a, s_b;
    @(negedge clk);
    act_a = a; act_b = b; wgt_a = wa; wgt_b = wb; rnd = r; valid_i = 1'b1;
    model(a, r, w_a, s_a);
    model(b, r, w_b, s_b);
    if ((a == 0) != (b == 0)) begin
      e.pack = {1'b1, (a == 0), 6'd0, (a == 0) ? b : a};
      e.ea   = (a == 0) ? 8'd0 : a;
      e.eb   = (a == 0) ? b : 8'd0;
    end else begin
      e.pack = {2'b00, s_b, s_a, w_b, w_a};
      e.ea   = 8'(int'(w_a) << s_a);
      e.eb   = 8'(int'(w_b) << s_b);
    end
    e.pa  = 16'(int'(e.ea) * int'(wa));
    e.pb  = 16'(int'(e.eb) * int'(wb));
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      act_a = 8'hA5; act_b = 8'h5A;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (sb.size() == 0) begin
          check("R10 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " pack"}, 32'(pack_o), 32'(e.pack));
          check("R8 exp_a", 32'(exp_a), 32'(e.ea));
          check("R8 exp_b", 32'(exp_b), 32'(e.eb));
          check("R9 prod_a", 32'(prod_a), 32'(e.pa));
          check("R9 prod_b", 32'(prod_b), 32'(e.pb));
          check("R10 latency", 32'(cyc), 32'(e.due));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 32'(valid_o), 0);
    check("R10 reset pack", 32'(pack_o), 0);
    check("R9 reset prod", 32'({prod_a, prod_b}), 0);
    rst_n = 1'b1;
    idle(2);
    send(8'h05, 8'h0C, 8'd3,   8'd7,   1'b1, "R2");
    send(8'hB7, 8'h2A, 8'd200, 8'd17,  1'b0, "R1");
    send(8'h2E, 8'h17, 8'd9,   8'd255, 1'b1, "R3");
    send(8'h2E, 8'h17, 8'd9,   8'd255, 1'b0, "R1");
    idle(3);
    send(8'h7C, 8'h1F, 8'd11,  8'd13,  1'b1, "R4");
    send(8'hF8, 8'hFF, 8'd255, 8'd254, 1'b1, "R5");
    send(8'h00, 8'hD3, 8'd77,  8'd201, 1'b1, "R6");
    send(8'h9E, 8'h00, 8'd255, 8'd1,   1'b0, "R6");
    send(8'h00, 8'h00, 8'd5,   8'd6,   1'b1, "R7");
    send(8'h10, 8'hFF, 8'd128, 8'd128, 1'b0, "R7");
    idle(1);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg[31:24];
      b = lcg[23:16];
      if (lcg[3:2] == 2'b00) a = 8'h00;
      if (lcg[5:4] == 2'b00) b = 8'h00;
      send(a, b, lcg[15:8], lcg[7:0] ^ lcg[31:24], lcg[9], "R1 R3 R7 random");
      if (lcg[12:10] == 3'b000) idle(1);
    end
    idle(6);
    check("R10 drained", 32'(sb.size()), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule